// File: doc/BRIEF.md
# Wide Accumulator Operation Unit

This block holds two wide signed accumulators and applies one operation per clock to the accumulator chosen by a select input. Each accumulator is two product words wide plus a few guard bits. The block takes a double-word signed product from an external multiplier and can add or subtract it either aligned or moved down by one word. It also shifts, rounds, clears, saturates, copies one accumulator into the other, and runs one step of a non-restoring division or the remainder fix-up that follows the last step.

Every accepted operation updates three registered flags, negative, zero and overflow, from its result. Read-back views are always available. They give the upper product word of the selected accumulator shifted by one bit either way, a rounded upper word of each accumulator, and a rounded upper half of the product. A surrounding datapath issues operation codes, moves values in through the product input, and reads results back through the accumulator and view outputs.

With word width W and G guard bits, each accumulator is A = 2W+G bits and the product is 2W bits. "High word" means bits [2W-1:W], and sext() means sign extension to A bits.

Top module: `wide_acc_unit`

## Requirements
- R1: rst_n low clears both accumulators and all flags at once. Release is synchronised through two clock edges, so an operation presented during the first two rising edges after release has no effect.
- R2: With op_valid low, no state changes. An operation never changes the unselected accumulator. acc_sel=0 selects acc0 and acc_sel=1 selects acc1.
- R3: Code 0000 shifts the selected accumulator arithmetically right by one bit. Code 0001 shifts it left by one bit and sets V when bits [A-1] and [A-2] differed.
- R4: Code 0010 adds 2^(W-1) and then clears bits [W-1:0], which rounds half up to a word boundary. V reports overflow of that addition.
- R5: Code 0011 clears the selected accumulator, so afterwards Z=1 and N=0.
- R6: Code 0100 saturates. When bits [A-1:2W-1] are not all equal, the accumulator becomes 2^(2W-1)-1 (if it was positive) or -2^(2W-1) (if it was negative), sign-extended. Otherwise it is unchanged.
- R7: Code 1000 loads the selected accumulator with the value of the other one.
- R8: Code 1010 adds sext(P) to the accumulator and code 1011 subtracts it.
- R9: Code 1100 adds sext(P >>> W), with the shift arithmetic, and code 1101 subtracts it.
- R10: Code 1110 is a division step. If the accumulator sign equals the P sign it computes S = acc - sext(P), otherwise S = acc + sext(P). The result is {S[A-2:0], q}, where q=1 when the sign of S equals the P sign. Code 0101 adds sext(P) when the accumulator sign differs from the P sign, and otherwise leaves the accumulator as it is.
- R11: Codes 0110, 0111, 1001 and 1111 are reserved. They change neither accumulator nor any flag.
- R12: After every non-reserved accepted operation, N equals result bit [A-1] and Z is 1 exactly when the result is zero. V is set only by signed A-bit overflow of the shift-left or of an addition or subtraction (R4, R8, R9, R10), and is otherwise 0.
- R13: Views are combinational. hi_sr is bits [2W:W+1] of the selected accumulator and hi_sl is its bits [2W-2:W-1]. accN_rnd is bits [2W-1:W] of accN + 2^(W-1), and prod_rnd is bits [2W-1:W] of P + 2^(W-1), taken modulo 2^(2W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation enable for this cycle |
| op_code | input | 4 | Operation code |
| acc_sel | input | 1 | Selected accumulator (0 or 1) |
| prod | input | 2W | Signed product / divisor operand |
| acc0 | output | 2W+G | Accumulator 0 |
| acc1 | output | 2W+G | Accumulator 1 |
| hi_sr | output | W | Selected high word, one bit right |
| hi_sl | output | W | Selected high word, one bit left |
| acc0_rnd | output | W | Rounded high word of accumulator 0 |
| acc1_rnd | output | W | Rounded high word of accumulator 1 |
| prod_rnd | output | W | Rounded high half of the product |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The hardest states to reach from the ports are the ones where the guard bits disagree, because saturation and the overflow flag only act there. Getting to them means first loading large products and then adding them repeatedly or shifting left. The bench therefore uses a small word width, so that a few aligned additions of the largest product leave the product range and a run of left shifts overflows the full accumulator. A sweep over every operation code, both selects and a spread of product values then reaches these states many times. It also walks through division sequences whose operand signs differ.

// File: rtl/wau_pkg.sv
package wau_pkg;
  localparam int NUM_ACC = 2;

  typedef enum logic [3:0] {
    OP_SRA  = 4'h0,
    OP_SLA  = 4'h1,
    OP_RND  = 4'h2,
    OP_CLR  = 4'h3,
    OP_SAT  = 4'h4,
    OP_RST  = 4'h5,
    OP_CPY  = 4'h8,
    OP_ADD  = 4'hA,
    OP_SUB  = 4'hB,
    OP_ADDH = 4'hC,
    OP_SUBH = 4'hD,
    OP_DIV  = 4'hE
  } wau_op_e;

  function automatic logic op_is_reserved(input logic [3:0] op);
    return (op == 4'h6) || (op == 4'h7) || (op == 4'h9) || (op == 4'hF);
  endfunction
endpackage

// File: rtl/wau_rounder.sv
module wau_rounder #(
  parameter int IN_W   = 48,
  parameter int WORD_W = 24
) (
  input  logic [IN_W-1:0]   val_i,
  output logic [WORD_W-1:0] rnd_o
);
  localparam int HI_LSB = WORD_W;
  localparam int HI_MSB = 2*WORD_W - 1;

  logic [IN_W-1:0] half;
  logic [IN_W-1:0] biased;

  always_comb begin
    half = '0;
    half[WORD_W-1] = 1'b1;
    biased = val_i + half;
  end

  assign rnd_o = biased[HI_MSB:HI_LSB];
endmodule

// File: rtl/wau_alu.sv
module wau_alu
  import wau_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int GUARD  = 4
) (
  input  logic [3:0]                  op_i,
  input  logic [2*WORD_W+GUARD-1:0]   acc_i,
  input  logic [2*WORD_W+GUARD-1:0]   other_i,
  input  logic [2*WORD_W-1:0]         prod_i,
  output logic [2*WORD_W+GUARD-1:0]   res_o,
  output logic                        ovf_o
);
  localparam int PW  = 2*WORD_W;
  localparam int AW  = PW + GUARD;
  localparam int MSB = AW - 1;

  logic [AW-1:0] p_full, p_down, add_b, add_bx, sum;
  logic [AW-1:0] sat_pos, sat_neg;
  logic          add_cin, a_s, p_s, add_ovf, need_sat;
  logic [GUARD:0] guard_bits;

  assign a_s    = acc_i[MSB];
  assign p_s    = prod_i[PW-1];
  assign p_full = {{GUARD{p_s}}, prod_i};
  assign p_down = {{(GUARD+WORD_W){p_s}}, prod_i[PW-1:WORD_W]};
  assign sat_pos = {{(GUARD+1){1'b0}}, {(PW-1){1'b1}}};
  assign sat_neg = ~sat_pos;
  assign guard_bits = acc_i[MSB:PW-1];
  assign need_sat = !((&guard_bits) || !(|guard_bits));

  // shared adder operand selection
  always_comb begin
    add_b   = '0;
    add_cin = 1'b0;
    case (op_i)
      OP_RND:  add_b[WORD_W-1] = 1'b1;
      OP_RST:  add_b = (a_s != p_s) ? p_full : '0;
      OP_DIV:  begin add_b = p_full; add_cin = (a_s == p_s); end
      OP_ADD:  add_b = p_full;
      OP_SUB:  begin add_b = p_full; add_cin = 1'b1; end
      OP_ADDH: add_b = p_down;
      OP_SUBH: begin add_b = p_down; add_cin = 1'b1; end
      default: add_b = '0;
    endcase
    add_bx  = add_cin ? ~add_b : add_b;
    sum     = acc_i + add_bx + AW'(add_cin);
    add_ovf = (a_s == add_bx[MSB]) && (sum[MSB] != a_s);
  end

  // result selection
  always_comb begin
    res_o = acc_i;
    ovf_o = 1'b0;
    case (op_i)
      OP_SRA: res_o = {a_s, acc_i[MSB:1]};
      OP_SLA: begin
        res_o = {acc_i[MSB-1:0], 1'b0};
        ovf_o = acc_i[MSB] ^ acc_i[MSB-1];
      end
      OP_RND: begin
        res_o = {sum[MSB:WORD_W], {WORD_W{1'b0}}};
        ovf_o = add_ovf;
      end
      OP_CLR: res_o = '0;
      OP_SAT: res_o = need_sat ? (a_s ? sat_neg : sat_pos) : acc_i;
      OP_CPY: res_o = other_i;
      OP_RST, OP_ADD, OP_SUB, OP_ADDH, OP_SUBH: begin
        res_o = sum;
        ovf_o = add_ovf;
      end
      OP_DIV: begin
        res_o = {sum[MSB-1:0], ~(sum[MSB] ^ p_s)};
        ovf_o = add_ovf;
      end
      default: begin
        res_o = acc_i;
        ovf_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/wide_acc_unit.sv
module wide_acc_unit
  import wau_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int GUARD  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [3:0]                  op_code,
  input  logic                        acc_sel,
  input  logic [2*WORD_W-1:0]         prod,
  output logic [2*WORD_W+GUARD-1:0]   acc0,
  output logic [2*WORD_W+GUARD-1:0]   acc1,
  output logic [WORD_W-1:0]           hi_sr,
  output logic [WORD_W-1:0]           hi_sl,
  output logic [WORD_W-1:0]           acc0_rnd,
  output logic [WORD_W-1:0]           acc1_rnd,
  output logic [WORD_W-1:0]           prod_rnd,
  output logic                        flag_n,
  output logic                        flag_z,
  output logic                        flag_v
);
  localparam int PW  = 2*WORD_W;
  localparam int AW  = PW + GUARD;
  localparam int MSB = AW - 1;

  // reset release synchroniser
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [AW-1:0] acc_q [NUM_ACC];
  logic [AW-1:0] acc_d [NUM_ACC];
  logic          n_q, z_q, v_q, n_d, z_d, v_d;
  logic          wr_en;
  logic [AW-1:0] alu_res, sel_acc;
  logic          alu_ovf;

  assign wr_en   = op_valid && !op_is_reserved(op_code);
  assign sel_acc = acc_q[acc_sel];

  wau_alu #(.WORD_W(WORD_W), .GUARD(GUARD)) i_alu (
    .op_i    (op_code),
    .acc_i   (sel_acc),
    .other_i (acc_q[~acc_sel]),
    .prod_i  (prod),
    .res_o   (alu_res),
    .ovf_o   (alu_ovf)
  );

  // next state
  always_comb begin
    acc_d = acc_q;
    acc_d[acc_sel] = alu_res;
    n_d = alu_res[MSB];
    z_d = (alu_res == '0);
    v_d = alu_ovf;
  end

  // registers with written-out enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q <= '{default: '0};
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      v_q   <= 1'b0;
    end else if (wr_en) begin
      acc_q <= acc_d;
      n_q   <= n_d;
      z_q   <= z_d;
      v_q   <= v_d;
    end
  end

  assign acc0   = acc_q[0];
  assign acc1   = acc_q[1];
  assign flag_n = n_q;
  assign flag_z = z_q;
  assign flag_v = v_q;

  // read-back views
  assign hi_sr = sel_acc[PW:WORD_W+1];
  assign hi_sl = sel_acc[PW-2:WORD_W-1];

  logic [WORD_W-1:0] rnd_w [NUM_ACC];
  for (genvar g = 0; g < NUM_ACC; g++) begin : g_rnd
    wau_rounder #(.IN_W(AW), .WORD_W(WORD_W)) i_rnd (
      .val_i (acc_q[g]),
      .rnd_o (rnd_w[g])
    );
  end
  assign acc0_rnd = rnd_w[0];
  assign acc1_rnd = rnd_w[1];

  wau_rounder #(.IN_W(PW), .WORD_W(WORD_W)) i_prnd (
    .val_i (prod),
    .rnd_o (prod_rnd)
  );

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !op_valid |=> $stable(acc0) && $stable(acc1) && $stable({flag_n, flag_z, flag_v}));
  // R2
  other0_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && acc_sel) |=> $stable(acc0));
  // R2
  other1_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !acc_sel) |=> $stable(acc1));
  // R11
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_is_reserved(op_code)) |=>
      $stable(acc0) && $stable(acc1) && $stable({flag_n, flag_z, flag_v}));
  // R5
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_code == OP_CLR) |=> flag_z && !flag_n && !flag_v);
  // R6
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_code == OP_SAT) |=>
      ((&acc_q[$past(acc_sel)][MSB:PW-1]) || !(|acc_q[$past(acc_sel)][MSB:PW-1])));
  // R12
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !op_is_reserved(op_code)) |=>
      (flag_z == (acc_q[$past(acc_sel)] == '0)) && (flag_n == acc_q[$past(acc_sel)][MSB]));
endmodule

// File: tb/test_wide_acc_unit.sv
`timescale 1ns/1ps
module test_wide_acc_unit;
  localparam int W  = 6;
  localparam int G  = 4;
  localparam int PW = 2*W;
  localparam int AW = PW + G;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [3:0]    op_code;
  logic          acc_sel;
  logic [PW-1:0] prod;
  logic [AW-1:0] acc0, acc1;
  logic [W-1:0]  hi_sr, hi_sl, acc0_rnd, acc1_rnd, prod_rnd;
  logic          flag_n, flag_z, flag_v;

  int n_tests = 0;
  int n_fail  = 0;

  logic [AW-1:0] m_acc [2];
  logic          m_n, m_z, m_v;

  always #4 clk = ~clk;

  wide_acc_unit #(.WORD_W(W), .GUARD(G)) i_wide_acc_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .prod(prod), .acc0(acc0), .acc1(acc1),
    .hi_sr(hi_sr), .hi_sl(hi_sl), .acc0_rnd(acc0_rnd), .acc1_rnd(acc1_rnd),
    .prod_rnd(prod_rnd), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  function automatic int sa16(input logic [AW-1:0] x);
    return int'($signed(x));
  endfunction
  function automatic int sp12(input logic [PW-1:0] x);
    return int'($signed(x));
  endfunction
  function automatic logic [AW-1:0] w16(input int x);
    logic [31:0] t;
    t = x;
    return t[AW-1:0];
  endfunction
  function automatic logic ovf(input int x);
    return (x > 32767) || (x < -32768);
  endfunction
  function automatic logic [W-1:0] hiw(input int x);
    logic [31:0] t;
    t = x >>> W;
    return t[W-1:0];
  endfunction

  function automatic string req_of(input logic v, input logic [3:0] op);
    if (!v) return "R2";
    case (op)
      4'h0, 4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return "R6";
      4'h5, 4'hE: return "R10";
      4'h8: return "R7";
      4'hA, 4'hB: return "R8";
      4'hC, 4'hD: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_op(input logic [3:0] op, input logic sel, input logic [PW-1:0] p);
    int sa, sp, x;
    logic [AW-1:0] r, d;
    logic v;
    sa = sa16(m_acc[sel]);
    sp = sp12(p);
    v  = 1'b0;
    r  = m_acc[sel];
    case (op)
      4'h0: r = w16(sa >>> 1);
      4'h1: begin x = sa * 2; r = w16(x); v = ovf(x); end
      4'h2: begin x = sa + 32; r = w16(x) & 16'hFFC0; v = ovf(x); end
      4'h3: r = '0;
      4'h4: begin
        if (sa > 2047) r = w16(2047);
        else if (sa < -2048) r = w16(-2048);
      end
      4'h5: begin x = ((sa < 0) != (sp < 0)) ? sa + sp : sa; r = w16(x); v = ovf(x); end
      4'h8: r = m_acc[!sel];
      4'hA: begin x = sa + sp; r = w16(x); v = ovf(x); end
      4'hB: begin x = sa - sp; r = w16(x); v = ovf(x); end
      4'hC: begin x = sa + (sp >>> W); r = w16(x); v = ovf(x); end
      4'hD: begin x = sa - (sp >>> W); r = w16(x); v = ovf(x); end
      4'hE: begin
        x = ((sa < 0) == (sp < 0)) ? sa - sp : sa + sp;
        d = w16(x);
        r = {d[AW-2:0], (d[AW-1] == (sp < 0))};
        v = ovf(x);
      end
      default: return;
    endcase
    m_acc[sel] = r;
    m_n = r[AW-1];
    m_z = (r == '0);
    m_v = v;
  endtask

  task automatic check_views();
    int sa;
    sa = sa16(m_acc[acc_sel]);
    chk("R13", "hi_sr", 32'(hi_sr), 32'(hiw(sa >>> 1)));
    chk("R13", "hi_sl", 32'(hi_sl), 32'(hiw(sa * 2)));
    chk("R13", "acc0_rnd", 32'(acc0_rnd), 32'(hiw(sa16(m_acc[0]) + 32)));
    chk("R13", "acc1_rnd", 32'(acc1_rnd), 32'(hiw(sa16(m_acc[1]) + 32)));
    chk("R13", "prod_rnd", 32'(prod_rnd), 32'(hiw(sp12(prod) + 32)));
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic sel, input logic [PW-1:0] p);
    string rq;
    op_valid = v; op_code = op; acc_sel = sel; prod = p;
    #1;
    check_views();
    @(posedge clk);
    if (v) model_op(op, sel, p);
    @(negedge clk);
    rq = req_of(v, op);
    chk(sel ? rq : "R2", "acc1", 32'(acc1), 32'(m_acc[1]));
    chk(sel ? "R2" : rq, "acc0", 32'(acc0), 32'(m_acc[0]));
    chk((v && op != 4'h6 && op != 4'h7 && op != 4'h9 && op != 4'hF) ? "R12" : rq,
        "flags", 32'({flag_n, flag_z, flag_v}), 32'({m_n, m_z, m_v}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_acc[0] = '0; m_acc[1] = '0; m_n = 0; m_z = 0; m_v = 0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; acc_sel = 1'b0; prod = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "acc0 reset", 32'(acc0), 32'h0);
    chk("R1", "acc1 reset", 32'(acc1), 32'h0);
    chk("R1", "flags reset", 32'({flag_n, flag_z, flag_v}), 32'h0);
    // R1 operation during synchronised release is dropped
    rst_n = 1'b1; op_valid = 1'b1; op_code = 4'hA; prod = 12'h155;
    @(posedge clk); @(negedge clk);
    chk("R1", "acc0 edge1", 32'(acc0), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R1", "acc0 edge2", 32'(acc0), 32'h0);
    op_valid = 1'b0;
    @(posedge clk); @(negedge clk);

    // directed: saturation (R6) and overflow (R12)
    step(1, 4'h3, 0, 12'h000);
    step(1, 4'hA, 0, 12'h7FF);
    step(1, 4'hA, 0, 12'h7FF);
    step(1, 4'h4, 0, 12'h000);
    step(1, 4'hB, 1, 12'h800);
    step(1, 4'h4, 1, 12'h000);
    for (int i = 0; i < 6; i++) step(1, 4'h1, 0, 12'h000);
    step(1, 4'h4, 0, 12'h000);
    // R7 copy, R11 reserved, R2 idle
    step(1, 4'h8, 1, 12'h000);
    step(1, 4'h6, 0, 12'hABC);
    step(1, 4'h7, 1, 12'h123);
    step(1, 4'h9, 0, 12'h800);
    step(1, 4'hF, 1, 12'h7FF);
    step(0, 4'h3, 0, 12'h000);
    // R10 division sequences with both sign pairings
    for (int s = 0; s < 4; s++) begin
      step(1, 4'h3, 0, 12'h000);
      step(1, 4'hA, 0, (s[0]) ? 12'hF9C : 12'h064);
      for (int k = 0; k < 5; k++) step(1, 4'hE, 0, (s[1]) ? 12'hFF9 : 12'h007);
      step(1, 4'h5, 0, (s[1]) ? 12'hFF9 : 12'h007);
    end
    // sweep every code, both selects, a spread of products
    for (int op = 0; op < 16; op++)
      for (int sel = 0; sel < 2; sel++)
        for (int k = 0; k < 32; k++)
          step(1, 4'(op), 1'(sel), 12'(k * 389 + op * 71));
    // random walk
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, 4'($urandom), 1'($urandom), 12'($urandom));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule